// File: doc/BRIEF.md
# Atomic 64-bit Compare-and-Swap Unit

This unit carries out one indivisible compare-and-exchange on a single 64-bit word held in memory. It is loaded with a start pulse. The pulse supplies three things: a word address, an expected value given as a high and a low 32-bit half, and a replacement value given as a second pair of halves. The unit then reads the word over a simple request/acknowledge memory bus and compares all 64 bits with the expected value. After that it always writes the word back. On a match it writes the replacement value. On a mismatch it writes the unchanged value it just read.

When the caller asks for locked operation, the bus lock output covers the whole read-compare-write window without a break. Other bus masters therefore never see a locked read without its locked write. The result is returned as a zero flag, set on a match and cleared on a mismatch. On a mismatch the expected-value pair is also updated with the value found in memory, so the caller can retry with it directly.

Top module: `cas64_unit`

## Requirements
- R1: A start pulse while `busy_o` is low latches the address, both value pairs and the lock request. `busy_o` is high from the next cycle up to and including the cycle in which `done_o` is high, and is low in the cycle after that.
- R2: Each accepted operation issues exactly one read request to the latched address, followed by exactly one write request to the same address. The write request is never raised before the read data has been accepted.
- R3: If the 64-bit memory word equals {`cmp_hi_i`, `cmp_lo_i`} (high half in bits 63:32), the written data is {`new_hi_i`, `new_lo_i`} (high half in bits 63:32), `zf_o` is 1 at `done_o`, and `exp_hi_o`/`exp_lo_o` still hold the expected halves.
- R4: On a mismatch, `zf_o` is 0 at `done_o`, the written data equals the word that was read, and `exp_hi_o`/`exp_lo_o` hold bits 63:32 and 31:0 of that word.
- R5: With the lock requested, `mem_lock_o` is high in every cycle from the first read-request cycle through the write-acknowledge cycle, with no low cycle in between.
- R6: `mem_lock_o` is low in the cycle after the write acknowledge. In that same cycle `done_o` is high for exactly one cycle.
- R7: With the lock not requested, the same read-compare-write sequence runs and `mem_lock_o` stays low throughout.
- R8: A start pulse while `busy_o` is high is ignored. It changes neither the result nor the memory traffic, and it does not begin a second operation.
- R9: When memory acknowledges each request in its first cycle, `done_o` is high in the fourth cycle counted from the cycle in which start is sampled.
- R10: After reset, `busy_o`, `done_o`, `zf_o`, both request outputs, `mem_lock_o` and both expected-half outputs are 0.
- R11: The comparison covers all 64 bits. A difference in any single bit, in either half, gives a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| lock_req_i | input | 1 | Request locked bus operation |
| addr_i | input | ADDR_W | Word address of the memory operand |
| cmp_hi_i | input | HALF_W | Expected value, bits 63:32 |
| cmp_lo_i | input | HALF_W | Expected value, bits 31:0 |
| new_hi_i | input | HALF_W | Replacement value, bits 63:32 |
| new_lo_i | input | HALF_W | Replacement value, bits 31:0 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| zf_o | output | 1 | 1 when the compare matched |
| exp_hi_o | output | HALF_W | Expected pair high half (memory value on mismatch) |
| exp_lo_o | output | HALF_W | Expected pair low half (memory value on mismatch) |
| mem_rd_req_o | output | 1 | Read request, held until read data is valid |
| mem_wr_req_o | output | 1 | Write request, held until acknowledged |
| mem_addr_o | output | ADDR_W | Bus address |
| mem_wdata_o | output | 2*HALF_W | Write data |
| mem_lock_o | output | 1 | Bus lock |
| mem_rdata_i | input | 2*HALF_W | Read data |
| mem_rvalid_i | input | 1 | Read data valid, acknowledges the read |
| mem_wack_i | input | 1 | Write acknowledge |

## Verification
The assertions check the bus and handshake timing on every cycle. They cover the single-cycle completion pulse, the lock dropping exactly one cycle after the write acknowledge and never at any other point, no lock while idle, the quiet cycle between read acceptance and write request, and busy staying high until completion whatever start does. The data side can only be shown by the bench's scenarios against a memory model: which value lands in memory, the flag, the expected-pair update on mismatch, single-bit differences at both ends of the word, and that a start pulse during an operation leaves no trace in the traffic.

// File: rtl/cas64_pkg.sv
package cas64_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_COMP  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } cas_state_e;
endpackage

// File: rtl/cas64_ctrl.sv
module cas64_ctrl
  import cas64_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rvalid_i,
  input  logic wack_i,
  input  logic lock_en_i,
  output logic accept_o,
  output logic capture_o,
  output logic eval_o,
  output logic rd_req_o,
  output logic wr_req_o,
  output logic lock_o,
  output logic busy_o,
  output logic done_o
);
  cas_state_e state_q, state_n;

  // next-state logic
  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE:  if (start_i)  state_n = ST_READ;
      ST_READ:  if (rvalid_i) state_n = ST_COMP;
      ST_COMP:                state_n = ST_WRITE;
      ST_WRITE: if (wack_i)   state_n = ST_DONE;
      ST_DONE:                state_n = ST_IDLE;
      default:                state_n = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  assign accept_o  = (state_q == ST_IDLE) && start_i;
  assign capture_o = (state_q == ST_READ) && rvalid_i;
  assign eval_o    = (state_q == ST_COMP);
  assign rd_req_o  = (state_q == ST_READ);
  assign wr_req_o  = (state_q == ST_WRITE);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  // lock covers read, compare and write; released in the done cycle
  assign lock_o    = lock_en_i &&
                     ((state_q == ST_READ) || (state_q == ST_COMP) || (state_q == ST_WRITE));
endmodule

// File: rtl/cas64_cmp.sv
module cas64_cmp #(
  parameter int WORD_W  = 64,
  parameter int SLICE_W = 16
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              eq_o
);
  localparam int SLICES = WORD_W / SLICE_W;

  logic [SLICES-1:0] slice_eq;

  // per-slice equality, then a reduction, keeps the depth shallow
  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    assign slice_eq[s] = (a_i[s*SLICE_W +: SLICE_W] == b_i[s*SLICE_W +: SLICE_W]);
  end

  assign eq_o = &slice_eq;
endmodule

// File: rtl/cas64_regs.sv
module cas64_regs #(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept_i,
  input  logic                  capture_i,
  input  logic                  eval_i,
  input  logic                  eq_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  lock_req_i,
  input  logic [HALF_W-1:0]     cmp_hi_i,
  input  logic [HALF_W-1:0]     cmp_lo_i,
  input  logic [HALF_W-1:0]     new_hi_i,
  input  logic [HALF_W-1:0]     new_lo_i,
  input  logic [2*HALF_W-1:0]   rdata_i,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  lock_en_o,
  output logic [HALF_W-1:0]     exp_hi_o,
  output logic [HALF_W-1:0]     exp_lo_o,
  output logic [2*HALF_W-1:0]   rd_word_o,
  output logic [2*HALF_W-1:0]   wdata_o,
  output logic                  zf_o
);
  localparam int WORD_W = 2 * HALF_W;

  logic [ADDR_W-1:0] addr_q;
  logic              lock_q;
  logic [HALF_W-1:0] exp_hi_q, exp_lo_q;
  logic [WORD_W-1:0] new_q, rd_q, wdata_q;
  logic              zf_q;

  // operands, loaded on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lock_q <= 1'b0;
      new_q  <= '0;
    end else if (accept_i) begin
      addr_q <= addr_i;
      lock_q <= lock_req_i;
      new_q  <= {new_hi_i, new_lo_i};
    end
  end

  // expected pair: loaded on accept, overwritten with memory on mismatch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_hi_q <= '0;
      exp_lo_q <= '0;
    end else if (accept_i) begin
      exp_hi_q <= cmp_hi_i;
      exp_lo_q <= cmp_lo_i;
    end else if (eval_i && !eq_i) begin
      exp_hi_q <= rd_q[WORD_W-1:HALF_W];
      exp_lo_q <= rd_q[HALF_W-1:0];
    end
  end

  // read data capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_q <= '0;
    else if (capture_i) rd_q <= rdata_i;
  end

  // result flag and write data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zf_q    <= 1'b0;
      wdata_q <= '0;
    end else if (eval_i) begin
      zf_q    <= eq_i;
      wdata_q <= eq_i ? new_q : rd_q;
    end
  end

  assign addr_o    = addr_q;
  assign lock_en_o = lock_q;
  assign exp_hi_o  = exp_hi_q;
  assign exp_lo_o  = exp_lo_q;
  assign rd_word_o = rd_q;
  assign wdata_o   = wdata_q;
  assign zf_o      = zf_q;
endmodule

// File: rtl/cas64_unit.sv
module cas64_unit #(
  parameter int ADDR_W  = 32,
  parameter int HALF_W  = 32,
  parameter int SLICE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                lock_req_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [HALF_W-1:0]   cmp_hi_i,
  input  logic [HALF_W-1:0]   cmp_lo_i,
  input  logic [HALF_W-1:0]   new_hi_i,
  input  logic [HALF_W-1:0]   new_lo_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                zf_o,
  output logic [HALF_W-1:0]   exp_hi_o,
  output logic [HALF_W-1:0]   exp_lo_o,
  output logic                mem_rd_req_o,
  output logic                mem_wr_req_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [2*HALF_W-1:0] mem_wdata_o,
  output logic                mem_lock_o,
  input  logic [2*HALF_W-1:0] mem_rdata_i,
  input  logic                mem_rvalid_i,
  input  logic                mem_wack_i
);
  localparam int WORD_W = 2 * HALF_W;

  logic              accept, capture, eval, eq, lock_en;
  logic [WORD_W-1:0] rd_word;

  cas64_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rvalid_i  (mem_rvalid_i),
    .wack_i    (mem_wack_i),
    .lock_en_i (lock_en),
    .accept_o  (accept),
    .capture_o (capture),
    .eval_o    (eval),
    .rd_req_o  (mem_rd_req_o),
    .wr_req_o  (mem_wr_req_o),
    .lock_o    (mem_lock_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  cas64_regs #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .capture_i  (capture),
    .eval_i     (eval),
    .eq_i       (eq),
    .addr_i     (addr_i),
    .lock_req_i (lock_req_i),
    .cmp_hi_i   (cmp_hi_i),
    .cmp_lo_i   (cmp_lo_i),
    .new_hi_i   (new_hi_i),
    .new_lo_i   (new_lo_i),
    .rdata_i    (mem_rdata_i),
    .addr_o     (mem_addr_o),
    .lock_en_o  (lock_en),
    .exp_hi_o   (exp_hi_o),
    .exp_lo_o   (exp_lo_o),
    .rd_word_o  (rd_word),
    .wdata_o    (mem_wdata_o),
    .zf_o       (zf_o)
  );

  // the expected pair is unchanged until the compare cycle, so it is the operand
  cas64_cmp #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_cmp (
    .a_i  (rd_word),
    .b_i  ({exp_hi_o, exp_lo_o}),
    .eq_o (eq)
  );
endmodule

// File: rtl/cas64_chk.sv
module cas64_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_o,
  input logic done_o,
  input logic mem_rd_req_o,
  input logic mem_wr_req_o,
  input logic mem_lock_o,
  input logic mem_rvalid_i,
  input logic mem_wack_i
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_lock_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req_o && mem_wack_i) |=> (done_o && !mem_lock_o));

  assert_lock_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock_o) |-> done_o);

  assert_idle_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_lock_o);

  assert_done_while_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  assert_read_then_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req_o && mem_rvalid_i) |=> (!mem_rd_req_o && !mem_wr_req_o && busy_o));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind cas64_unit cas64_chk u_chk (.*);

// File: tb/tb_cas64_unit.sv
module tb_cas64_unit;
  localparam int AW = 32;
  localparam int HW = 32;

  logic          clk, rst_n, start, lock_req;
  logic [AW-1:0] addr;
  logic [HW-1:0] cmp_hi, cmp_lo, new_hi, new_lo;
  logic          busy, done, zf;
  logic [HW-1:0] exp_hi, exp_lo;
  logic          rd_req, wr_req, lock;
  logic [AW-1:0] maddr;
  logic [63:0]   wdata, rdata;
  logic          rvalid, wack;

  cas64_unit #(.ADDR_W(AW), .HALF_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lock_req_i(lock_req),
    .addr_i(addr), .cmp_hi_i(cmp_hi), .cmp_lo_i(cmp_lo),
    .new_hi_i(new_hi), .new_lo_i(new_lo),
    .busy_o(busy), .done_o(done), .zf_o(zf),
    .exp_hi_o(exp_hi), .exp_lo_o(exp_lo),
    .mem_rd_req_o(rd_req), .mem_wr_req_o(wr_req), .mem_addr_o(maddr),
    .mem_wdata_o(wdata), .mem_lock_o(lock),
    .mem_rdata_i(rdata), .mem_rvalid_i(rvalid), .mem_wack_i(wack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [63:0] mem [16];
  int rd_cnt, wr_cnt, lock_err, order_err, rd_wait, wr_wait;
  logic op_lock;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // memory model and bus monitor, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !done) begin
        if (lock !== op_lock) lock_err++;
      end else if (lock !== 1'b0) lock_err++;
      if (wr_req && rd_cnt == 0) order_err++;
      if (rvalid) rvalid = 1'b0;
      else if (rd_req) begin
        if (rd_wait == 0) begin
          rvalid = 1'b1; rdata = mem[maddr[3:0]]; rd_cnt++;
        end else rd_wait--;
      end
      if (wack) wack = 1'b0;
      else if (wr_req) begin
        if (wr_wait == 0) begin
          wack = 1'b1; mem[maddr[3:0]] = wdata; wr_cnt++;
        end else wr_wait--;
      end
    end
  end

  task automatic run_op(input logic [3:0] a, input logic [63:0] cv, input logic [63:0] nv,
                        input logic lk, input bit zero_wait, input bit poke);
    logic [63:0] old, exp_mem, exp_pair;
    bit          eq;
    int          n;
    old      = mem[a];
    eq       = (old == cv);
    exp_mem  = eq ? nv : old;
    exp_pair = eq ? cv : old;
    rd_cnt = 0; wr_cnt = 0; lock_err = 0; order_err = 0;
    rd_wait = zero_wait ? 0 : $urandom_range(0, 2);
    wr_wait = zero_wait ? 0 : $urandom_range(0, 2);
    @(negedge clk);
    op_lock = lk;
    addr = {28'h0, a}; cmp_hi = cv[63:32]; cmp_lo = cv[31:0];
    new_hi = nv[63:32]; new_lo = nv[31:0]; lock_req = lk; start = 1'b1;
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1) start = 1'b0;
      if (poke && n == 2) begin
        start = 1'b1; addr = {28'h0, a + 4'd1}; cmp_hi = ~cv[63:32]; cmp_lo = ~cv[31:0];
        new_hi = 32'hDEAD_0000; new_lo = 32'h0000_BEEF; lock_req = ~lk;
      end
      if (poke && n == 3) start = 1'b0;
      if (done || n > 40) break;
    end
    check(done === 1'b1, "R1 done seen", {63'd0, done}, 64'd1);
    check(zf === eq, eq ? "R3 zf on match" : "R4 zf on mismatch", {63'd0, zf}, {63'd0, eq});
    check({exp_hi, exp_lo} === exp_pair, eq ? "R3 expected pair kept" : "R4 expected pair loaded",
          {exp_hi, exp_lo}, exp_pair);
    check(mem[a] === exp_mem, eq ? "R3 new value written" : "R4 old value written back",
          mem[a], exp_mem);
    check(lock_err == 0, lk ? "R5 lock held through sequence" : "R7 lock stays low",
          64'(lock_err), 64'd0);
    if (zero_wait) check(n == 4, "R9 zero-wait latency", 64'(n), 64'd4);
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R6 done one cycle, R1 busy low after",
          {62'd0, busy, done}, 64'd0);
    repeat (2) @(negedge clk);
    check(rd_cnt == 1 && wr_cnt == 1 && order_err == 0,
          poke ? "R8 start ignored while busy" : "R2 one read then one write",
          {32'(rd_cnt), 32'(wr_cnt)}, {32'd1, 32'd1});
  endtask

  initial begin
    logic [63:0] cv;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start = 1'b0; lock_req = 1'b0; addr = '0;
    cmp_hi = '0; cmp_lo = '0; new_hi = '0; new_lo = '0;
    rvalid = 1'b0; wack = 1'b0; rdata = '0; op_lock = 1'b0;
    rd_cnt = 0; wr_cnt = 0; lock_err = 0; order_err = 0; rd_wait = 0; wr_wait = 0;
    for (int i = 0; i < 16; i++) mem[i] = {32'hA500_0000 + 32'(i), 32'h3C00_0000 ^ (32'(i) * 32'h0101_0101)};
    repeat (3) @(negedge clk);
    check({busy, done, zf, rd_req, wr_req, lock} === 6'b0, "R10 reset outputs",
          {58'd0, busy, done, zf, rd_req, wr_req, lock}, 64'd0);
    check({exp_hi, exp_lo} === 64'd0, "R10 reset expected pair", {exp_hi, exp_lo}, 64'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed: match with lock, zero wait (R3, R5, R9)
    run_op(4'd2, mem[2], 64'h1122_3344_5566_7788, 1'b1, 1'b1, 1'b0);
    // mismatch with lock, zero wait (R4, R5, R6)
    run_op(4'd3, 64'h0, 64'hFFFF_0000_FFFF_0000, 1'b1, 1'b1, 1'b0);
    // single-bit differences at both ends (R11)
    cv = mem[5] ^ 64'h8000_0000_0000_0000;
    run_op(4'd5, cv, 64'h0BAD_F00D_0BAD_F00D, 1'b1, 1'b0, 1'b0);
    check(mem[5][63] !== cv[63], "R11 top bit difference seen", mem[5], ~cv);
    cv = mem[6] ^ 64'h1;
    run_op(4'd6, cv, 64'h0, 1'b0, 1'b0, 1'b0);
    check(mem[6][0] !== cv[0], "R11 bottom bit difference seen", mem[6], ~cv);
    // no lock, match (R7)
    run_op(4'd7, mem[7], 64'hCAFE_0001_CAFE_0002, 1'b0, 1'b1, 1'b0);
    // start during operation (R8)
    run_op(4'd8, mem[8], 64'h7777_6666_5555_4444, 1'b1, 1'b0, 1'b1);
    run_op(4'd9, 64'h1, 64'h2, 1'b0, 1'b1, 1'b1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 15));
      cv = ($urandom_range(0, 1) == 1) ? mem[a] : {$urandom(), $urandom()};
      run_op(a, cv, {$urandom(), $urandom()}, 1'($urandom_range(0, 1)),
             ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule